// File: doc/BRIEF.md
# Ones-Complement Rotating Checksum

This block folds a stream of words into a running ones-complement checksum. For each word, it adds the word to the running sum. A carry out of the top bit wraps around into bit 0. The block then rotates the sum left by one bit. A job begins with a start pulse, which supplies a word count and a starting sum. A fresh job starts from zero instead of the supplied sum. Words then arrive over a valid/ready stream, at most one per cycle.

When the last word has been absorbed, the block raises a one-cycle done strobe and presents the final checksum. An all-ones result is replaced by zero, because all-ones is reserved to mean "no checksum present". A job can also be cut short with an abort input. In that case the done strobe comes with a halted flag, the unmapped partial sum and the number of words not yet consumed. Feeding those two values into a later start resumes the computation where it stopped.

Top module: `ocsum_rot`

## Requirements
- R1: After reset, `done`, `halted` and `in_ready` are 0.
- R2: A start pulse while idle loads the running sum with 0 when `fresh` is 1, and with `init_sum` otherwise. It also loads the remaining count from `count`. A start pulse while a job is running has no effect on that job.
- R3: Each absorbed word updates the sum as rotl1(S ⊕ D). Here ⊕ is a W-bit add whose carry out of bit W-1 is added back into bit 0, and rotl1 moves bit W-1 to bit 0.
- R4: `in_ready` is 1 only while a job has words left and `abort` is 0. A word is absorbed on a clock edge where both `in_valid` and `in_ready` are 1, at most one per cycle. Cycles with `in_valid` at 0 stall the job without changing it.
- R5: `done` is 1 for exactly the cycle after the edge that absorbs the last word. In that cycle `result` holds the final sum, with an all-ones value replaced by 0, and `halted` and `remaining` are 0.
- R6: A start with `count` equal to 0 raises `done` in the next cycle. `result` then equals the starting sum, returned unchanged even if it is all-ones.
- R7: `abort` while a job runs ends the job. In the next cycle `done` and `halted` are 1, `result` holds the partial sum without the all-ones mapping, and `remaining` holds the number of words not absorbed. The word offered during the abort cycle is not taken.
- R8: Restarting with `fresh` at 0, `init_sum` set to the partial sum and `count` set to the remaining count gives the same final result as the uninterrupted job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (taken only while idle) |
| fresh | input | 1 | 1: start the sum at zero; 0: start at `init_sum` |
| init_sum | input | W | Starting partial sum |
| count | input | CW | Number of words in the job |
| in_valid | input | 1 | A word is offered |
| in_word | input | W | Offered word |
| in_ready | output | 1 | Block absorbs the offered word at this edge |
| abort | input | 1 | Stop the running job early |
| done | output | 1 | One-cycle completion strobe |
| halted | output | 1 | With `done`: the job was stopped early |
| result | output | W | Final checksum, or the partial sum when halted |
| remaining | output | CW | Words not absorbed (0 on normal completion) |

## Verification
The bench builds the block with W=4 and CW=4. This makes it possible to sweep every sum/word pair through a single step, and it makes an all-ones result common, so the zero mapping and its suppression on zero-count and halted jobs are exercised many times. With a 4-bit count, jobs of every length from 0 to 15 can be run. The bench can also stop a job at every word position and resume it, and compare the resumed result with the uninterrupted one.

// File: rtl/ocsum_rot.sv
module ocsum_rot #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fresh,
  input  logic [W-1:0]  init_sum,
  input  logic [CW-1:0] count,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  output logic          in_ready,
  input  logic          abort,
  output logic          done,
  output logic          halted,
  output logic [W-1:0]  result,
  output logic [CW-1:0] remaining
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          busy;
  logic [W-1:0]  sum;
  logic [CW-1:0] cnt;

  logic [W:0]    wide;
  logic [W-1:0]  folded, stepped, mapped, seed;
  logic          take;

  assign wide    = {1'b0, sum} + {1'b0, in_word};
  assign folded  = wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
  assign stepped = {folded[W-2:0], folded[W-1]};
  assign mapped  = (&stepped) ? '0 : stepped;
  assign seed    = fresh ? '0 : init_sum;

  assign in_ready = busy & ~abort;
  assign take     = in_ready & in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sum       <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      halted    <= 1'b0;
      result    <= '0;
      remaining <= '0;
    end else begin
      done   <= 1'b0;
      halted <= 1'b0;
      if (!busy && start) begin
        sum <= seed;
        cnt <= count;
        if (count == '0) begin
          done      <= 1'b1;
          result    <= seed;
          remaining <= '0;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy && abort) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        halted    <= 1'b1;
        result    <= sum;
        remaining <= cnt;
      end else if (take) begin
        sum <= stepped;
        cnt <= cnt - ONE;
        if (cnt == ONE) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          result    <= mapped;
          remaining <= '0;
        end
      end
    end
  end

  a_r4_ready_needs_job: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && cnt != '0));

  a_r4_one_word_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cnt == $past(cnt) - ONE);

  a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !abort && !in_valid) |=> (busy && cnt == $past(cnt) && sum == $past(sum)));

  a_r5_final_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt == ONE) |=> (done && !halted && remaining == '0 && !(&result)));

  a_r7_stop_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (done && halted && !busy && remaining == $past(cnt) && result == $past(sum)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

endmodule

// File: tb/test_ocsum_rot.sv
module test_ocsum_rot;
  localparam int W  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, fresh = 1'b0, in_valid = 1'b0, abort = 1'b0;
  logic [W-1:0]  init_sum = '0, in_word = '0;
  logic [CW-1:0] count = '0;
  logic          in_ready, done, halted;
  logic [W-1:0]  result;
  logic [CW-1:0] remaining;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [W-1:0] wv [16];

  always #10 clk = ~clk;

  ocsum_rot #(.W(W), .CW(CW)) i_ocsum_rot (
    .clk(clk), .rst_n(rst_n), .start(start), .fresh(fresh), .init_sum(init_sum),
    .count(count), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .abort(abort), .done(done), .halted(halted), .result(result), .remaining(remaining)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] mstep(input logic [W-1:0] s, input logic [W-1:0] d);
    int t;
    t = int'(s) + int'(d);
    if (t >= (1 << W)) t = t - (1 << W) + 1;
    t = (t * 2) % (1 << W) + (t >> (W - 1));
    return W'(t);
  endfunction

  function automatic logic [W-1:0] mfin(input logic [W-1:0] s);
    return (s == {W{1'b1}}) ? '0 : s;
  endfunction

  function automatic logic [W-1:0] mrun(input logic [W-1:0] s, input int from, input int upto);
    logic [W-1:0] a = s;
    for (int i = from; i < upto; i++) a = mstep(a, wv[i]);
    return a;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic kick(input logic f, input logic [W-1:0] ini, input int n);
    @(negedge clk);
    start = 1'b1; fresh = f; init_sum = ini; count = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int from, input int upto, input int gap, input logic poke);
    for (int i = from; i < upto; i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        in_valid = 1'b0;
        in_word = ~wv[i];
        @(negedge clk);
        chk("R4 stall keeps job open", int'(done), 0);
      end
      in_valid = 1'b1;
      in_word = wv[i];
      if (poke) begin
        start = 1'b1; fresh = 1'b1; count = '0;
      end
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      if (i < upto - 1) chk("R5 no early done", int'(done), 0);
    end
  endtask

  task automatic fill(input int seed);
    int x = seed * 7 + 3;
    for (int i = 0; i < 16; i++) begin
      x = (x * 13 + 5) % 251;
      wv[i] = W'(x);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 halted after reset", int'(halted), 0);
    chk("R1 in_ready after reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle not ready", int'(in_ready), 0);

    // R3 exhaustive single step over every sum/word pair
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        wv[0] = W'(d);
        kick(1'b0, W'(s), 1);
        chk("R4 ready while job open", int'(in_ready), 1);
        feed(0, 1, 0, 1'b0);
        chk("R5 done after last word", int'(done), 1);
        chk("R3 single step", int'(result), int'(mfin(mstep(W'(s), W'(d)))));
      end
    end

    // R6 zero count
    for (int s = 0; s < 16; s++) begin
      kick(1'b0, W'(s), 0);
      chk("R6 zero count done", int'(done), 1);
      chk("R6 zero count unchanged sum", int'(result), s);
      @(negedge clk);
      chk("R5 done is one cycle", int'(done), 0);
    end
    kick(1'b1, 4'hF, 0);
    chk("R2 fresh ignores init_sum", int'(result), 0);

    // R2 R5 multi-word jobs, with and without stalls
    for (int n = 1; n < 16; n++) begin
      for (int sd = 0; sd < 4; sd++) begin
        fill(n * 4 + sd);
        kick(sd[0], W'(n + sd), n);
        feed(0, n, sd[1] ? 3 : 0, 1'b0);
        chk("R5 done", int'(done), 1);
        chk("R5 halted low", int'(halted), 0);
        chk("R5 remaining zero", int'(remaining), 0);
        chk("R5 final sum", int'(result),
            int'(mfin(mrun(sd[0] ? '0 : W'(n + sd), 0, n))));
      end
    end

    // R2 start while running is ignored
    fill(99);
    kick(1'b0, 4'h5, 6);
    feed(0, 6, 0, 1'b1);
    chk("R2 start during job ignored", int'(result), int'(mfin(mrun(4'h5, 0, 6))));

    // R7 R8 stop at every position and resume
    for (int n = 1; n < 16; n += 2) begin
      for (int k = 0; k < n; k++) begin
        logic [W-1:0] part;
        fill(n + k * 3);
        kick(1'b0, W'(k), n);
        feed(0, k, 0, 1'b0);
        abort = 1'b1; in_valid = 1'b1; in_word = 4'hA;
        #1;
        chk("R4 ready low under abort", int'(in_ready), 0);
        @(negedge clk);
        abort = 1'b0; in_valid = 1'b0;
        part = mrun(W'(k), 0, k);
        chk("R7 stop done", int'(done), 1);
        chk("R7 stop halted", int'(halted), 1);
        chk("R7 partial unmapped", int'(result), int'(part));
        chk("R7 remaining count", int'(remaining), n - k);
        kick(1'b0, result, n - k);
        feed(k, n, 0, 1'b0);
        chk("R8 resumed equals whole", int'(result), int'(mfin(mrun(W'(k), 0, n))));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule